// File: doc/BRIEF.md
# Three-Voice Wavetable Sound Generator

This block produces mono game audio from three independent wavetable voices. A processor sets up each voice by writing bytes into a 32-byte register window on a simple write bus. The registers hold a 20-bit frequency step, a 4-bit volume and a 4-bit waveform select. An internal divider makes a sample tick once every `TICK_DIV` clocks; 1042 clocks at 100 MHz gives about 96 kHz. On each tick every voice adds its step to a 20-bit phase accumulator. The block then reads one nibble per voice from an external 16-waveform sound ROM of 32 samples each. The three voices take turns on a single read port with one cycle of latency.

Each fetched nibble is scaled by its voice's volume. The three results are added, and the sum is shifted left by two to form the mixed sample. The mixed sample is latched only after all three fetches complete, and `sample_valid_o` pulses at the same time. A free-running 8-bit counter turns the mixed sample into a one-bit PWM stream for a speaker pin. The PWM threshold is reloaded only when the counter wraps. By convention voices 0 and 1 carry music and voice 2 carries effects; the hardware treats all three alike.

Top module: `tri_voice_synth`

## Requirements
- R1: After reset, `sample_o` is 0, `sample_valid_o` is 0, `pwm_o` is 0, and every frequency, volume, waveform and accumulator register is 0.
- R2: On every sample tick, each voice's accumulator increases by its frequency value. The ROM address for a voice is `{wave[3:0], acc[19:15]}`: the waveform select sits in the upper 4 address bits.
- R3: Only bits [3:0] of the ROM byte form the voice sample. Bits [7:4] have no effect.
- R4: A voice contributes `(nibble * volume) >> 4`. A volume of 0 silences the voice.
- R5: `sample_o` equals the sum of the three voice contributions shifted left by 2. It is therefore a multiple of 4 and never above 168.
- R6: `sample_valid_o` is a one-cycle pulse once every `TICK_DIV` clocks. `sample_o` changes only in a cycle where `sample_valid_o` is 1.
- R7: Register map. A write is decoded only when `wr_addr_i[15:5]` equals `0x5040 >> 5`. The voice number is `wr_addr_i[4:3]`, giving voices 0, 1 and 2; slot 3 is ignored. Within a voice, `wr_addr_i[2:0]` selects the field: 0 writes frequency bits [7:0], 1 writes bits [15:8], 2 writes bits [19:16] from data bits [3:0], 3 writes the volume from data bits [3:0], and 4 writes the waveform from data bits [3:0]. Field offsets 5 to 7 and all addresses outside the window are ignored.
- R8: With a constant `sample_o`, any 256 consecutive clocks that start after the threshold has settled hold exactly `sample_o` cycles with `pwm_o` = 1.
- R9: The PWM threshold changes only on the clock at which the PWM counter wraps from 255 to 0.
- R10: Accumulators wrap modulo 2^20. The frequency's upper byte keeps only its low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register window |
| wr_addr_i | input | 16 | Write byte address |
| wr_data_i | input | 8 | Write data |
| rom_addr_o | output | 9 | Sound ROM address: {waveform, phase index} |
| rom_data_i | input | 8 | Sound ROM byte, valid one clock after its address |
| sample_o | output | 8 | Latest mixed sample |
| sample_valid_o | output | 1 | One-cycle pulse when sample_o updates |
| pwm_o | output | 1 | One-bit PWM speaker output |

## Verification
The assertions assume that `TICK_DIV` is larger than the fetch sequence, which lasts five clocks after a tick. They also assume the ROM returns data exactly one clock after the address. The bench's ROM model is a register clocked on the address, and the default divider is far above five. Register writes are applied only in the quiet stretch just after a `sample_valid_o` pulse, so a frequency change never lands on a tick. That lets the bench's accumulator model add the new step on the next tick. PWM duty is measured only in a window that opens 300 clocks after a sample update and closes well before the next one, so the threshold is steady across the whole window.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  localparam int unsigned NUM_VOICES = 3;
  localparam int unsigned ACC_W      = 20;
  localparam int unsigned WAVE_W     = 4;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned NIB_W      = 4;

  typedef enum logic [2:0] {
    FLD_FREQ_LO  = 3'd0,
    FLD_FREQ_MID = 3'd1,
    FLD_FREQ_HI  = 3'd2,
    FLD_VOLUME   = 3'd3,
    FLD_WAVE     = 3'd4
  } fld_e;
endpackage

// File: rtl/tvs_regs.sv
module tvs_regs
  import tvs_pkg::*;
#(
  parameter int unsigned NV        = NUM_VOICES,
  parameter int unsigned AW        = ACC_W,
  parameter logic [15:0] WIN_BASE  = 16'h5040
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [15:0]                   wr_addr_i,
  input  logic [7:0]                    wr_data_i,
  output logic [NV-1:0][AW-1:0]         freq_o,
  output logic [NV-1:0][NIB_W-1:0]      vol_o,
  output logic [NV-1:0][WAVE_W-1:0]     wave_o
);
  localparam int unsigned HI_W = AW - 16;

  logic in_win;
  assign in_win = wr_en_i && (wr_addr_i[15:5] == WIN_BASE[15:5]);

  for (genvar v = 0; v < NV; v++) begin : g_voice
    logic hit;
    assign hit = in_win && (wr_addr_i[4:3] == 2'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        freq_o[v] <= '0;
        vol_o[v]  <= '0;
        wave_o[v] <= '0;
      end else if (hit) begin
        case (wr_addr_i[2:0])
          FLD_FREQ_LO:  freq_o[v][7:0]     <= wr_data_i;
          FLD_FREQ_MID: freq_o[v][15:8]    <= wr_data_i;
          FLD_FREQ_HI:  freq_o[v][AW-1:16] <= wr_data_i[HI_W-1:0];
          FLD_VOLUME:   vol_o[v]           <= wr_data_i[NIB_W-1:0];
          FLD_WAVE:     wave_o[v]          <= wr_data_i[WAVE_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tvs_core.sv
module tvs_core
  import tvs_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1042,
  parameter int unsigned NV       = NUM_VOICES,
  parameter int unsigned AW       = ACC_W,
  parameter int unsigned SUM_W    = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NV-1:0][AW-1:0]         freq_i,
  input  logic [NV-1:0][NIB_W-1:0]      vol_i,
  input  logic [NV-1:0][WAVE_W-1:0]     wave_i,
  output logic [WAVE_W+IDX_W-1:0]       rom_addr_o,
  input  logic [7:0]                    rom_data_i,
  output logic [SUM_W+1:0]              sample_o,
  output logic                          sample_valid_o
);
  localparam int unsigned DIV_W     = $clog2(TICK_DIV);
  localparam int unsigned STEP_LAST = NV + 2;
  localparam int unsigned STEP_W    = $clog2(NV + 3);

  logic [DIV_W-1:0]       div_q;
  logic                   tick;
  logic [NV-1:0][AW-1:0]  acc_q;
  logic [STEP_W-1:0]      step_q;
  logic [SUM_W-1:0]       sum_q;
  logic                   cap_en;
  logic [NIB_W-1:0]       cap_vol;
  logic [7:0]             prod;
  logic                   unused_rom_hi;

  assign tick          = (div_q == DIV_W'(TICK_DIV - 1));
  assign unused_rom_hi = ^rom_data_i[7:NIB_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  for (genvar v = 0; v < NV; v++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q[v] <= '0;
      else if (tick) acc_q[v] <= acc_q[v] + freq_i[v];
    end
  end

  // step 1..NV issue voice step-1; step 2..NV+1 capture voice step-2; last step latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              step_q <= '0;
    else if (tick)                            step_q <= STEP_W'(1);
    else if (step_q == STEP_W'(STEP_LAST))    step_q <= '0;
    else if (step_q != '0)                    step_q <= step_q + 1'b1;
  end

  always_comb begin
    rom_addr_o = {wave_i[0], acc_q[0][AW-1 -: IDX_W]};
    for (int v = 0; v < NV; v++) begin
      if (step_q == STEP_W'(v + 1))
        rom_addr_o = {wave_i[v], acc_q[v][AW-1 -: IDX_W]};
    end
  end

  always_comb begin
    cap_en  = 1'b0;
    cap_vol = '0;
    for (int v = 0; v < NV; v++) begin
      if (step_q == STEP_W'(v + 2)) begin
        cap_en  = 1'b1;
        cap_vol = vol_i[v];
      end
    end
  end

  assign prod = {4'b0, rom_data_i[NIB_W-1:0]} * {4'b0, cap_vol};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (tick)   sum_q <= '0;
    else if (cap_en) sum_q <= sum_q + SUM_W'(prod[7:4]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else if (step_q == STEP_W'(STEP_LAST)) begin
      sample_o       <= {sum_q, 2'b00};
      sample_valid_o <= 1'b1;
    end else begin
      sample_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tvs_pwm.sv
module tvs_pwm #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      thr_o <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
      if (&cnt_o) thr_o <= sample_i;  // reload only at wrap
    end
  end
endmodule

// File: rtl/tri_voice_synth.sv
module tri_voice_synth
  import tvs_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1042,
  parameter logic [15:0] WIN_BASE = 16'h5040,
  parameter int unsigned NV       = NUM_VOICES,
  parameter int unsigned AW       = ACC_W,
  localparam int unsigned ROM_AW  = WAVE_W + IDX_W,
  localparam int unsigned SUM_W   = $clog2(15 * NV + 1),
  localparam int unsigned SMP_W   = SUM_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [7:0]        rom_data_i,
  output logic [SMP_W-1:0]  sample_o,
  output logic              sample_valid_o,
  output logic              pwm_o
);
  logic [NV-1:0][AW-1:0]     freq;
  logic [NV-1:0][NIB_W-1:0]  vol;
  logic [NV-1:0][WAVE_W-1:0] wave;
  logic [SMP_W-1:0]          pwm_cnt;
  logic [SMP_W-1:0]          pwm_thr;

  tvs_regs #(.NV(NV), .AW(AW), .WIN_BASE(WIN_BASE)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .freq_o    (freq),
    .vol_o     (vol),
    .wave_o    (wave)
  );

  tvs_core #(.TICK_DIV(TICK_DIV), .NV(NV), .AW(AW), .SUM_W(SUM_W)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .freq_i         (freq),
    .vol_i          (vol),
    .wave_i         (wave),
    .rom_addr_o     (rom_addr_o),
    .rom_data_i     (rom_data_i),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o)
  );

  tvs_pwm #(.W(SMP_W)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_o),
    .cnt_o    (pwm_cnt),
    .thr_o    (pwm_thr)
  );

  assign pwm_o = (pwm_cnt < pwm_thr);
endmodule

// File: rtl/tvs_checker.sv
module tvs_checker #(
  parameter int unsigned TICK_DIV = 1042,
  parameter int unsigned SMP_W    = 8,
  parameter int unsigned MAX_SMP  = 168
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SMP_W-1:0] sample_o,
  input logic             sample_valid_o,
  input logic             pwm_o,
  input logic [SMP_W-1:0] pwm_cnt,
  input logic [SMP_W-1:0] pwm_thr
);
  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (sample_valid_o) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);  // R6
  AST_VALID_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && seen_q) |-> (gap_q == TICK_DIV - 1));  // R6
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> $stable(sample_o));  // R6
  AST_SAMPLE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o <= SMP_W'(MAX_SMP)) && (sample_o[1:0] == 2'b00));  // R5
  AST_THR_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwm_thr) |-> ($past(pwm_cnt) == '1));  // R9
  AST_PWM_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_thr == '0) |-> !pwm_o);  // R8
endmodule

bind tri_voice_synth tvs_checker #(
  .TICK_DIV (TICK_DIV),
  .SMP_W    (SMP_W),
  .MAX_SMP  (14 * NV * 4)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o),
  .pwm_o          (pwm_o),
  .pwm_cnt        (pwm_cnt),
  .pwm_thr        (pwm_thr)
);

// File: tb/tri_voice_synth_test.sv
module tri_voice_synth_test;
  localparam int TICK_DIV = 1042;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [8:0] rom_addr;
  logic [7:0] rom_data;
  logic [7:0] sample;
  logic       sample_valid;
  logic       pwm;

  int checks = 0;
  int errors = 0;

  int m_freq [3];
  int m_vol  [3];
  int m_wave [3];
  int m_acc  [3];

  always #5 clk = ~clk;

  tri_voice_synth uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .wr_en_i        (wr_en),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .rom_addr_o     (rom_addr),
    .rom_data_i     (rom_data),
    .sample_o       (sample),
    .sample_valid_o (sample_valid),
    .pwm_o          (pwm)
  );

  function automatic int nib_of(input int a);
    return ((a & 15) * 5 + ((a >> 4) & 31) * 3 + 1) & 15;
  endfunction

  // synchronous ROM, one clock latency; upper nibble deliberately nonzero (R3)
  always_ff @(posedge clk) rom_data <= {rom_addr[3:0] ^ 4'h9, 4'(nib_of(int'(rom_addr)))};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_wr(input int a, input int d);
    int v;
    if ((a >> 5) != (16'h5040 >> 5)) return;
    v = (a >> 3) & 3;
    if (v > 2) return;
    case (a & 7)
      0: m_freq[v] = (m_freq[v] & 32'hFFF00) | d;
      1: m_freq[v] = (m_freq[v] & 32'hF00FF) | (d << 8);
      2: m_freq[v] = (m_freq[v] & 32'h0FFFF) | ((d & 15) << 16);
      3: m_vol[v]  = d & 15;
      4: m_wave[v] = d & 15;
      default: ;
    endcase
  endfunction

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 16'(a);
    wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic set_voice(input int v, input int f, input int vl, input int w);
    bus_wr(16'h5040 + v * 8 + 0, f & 255);
    bus_wr(16'h5040 + v * 8 + 1, (f >> 8) & 255);
    bus_wr(16'h5040 + v * 8 + 2, (f >> 16) & 255);
    bus_wr(16'h5040 + v * 8 + 3, vl);
    bus_wr(16'h5040 + v * 8 + 4, w);
  endtask

  task automatic wait_valid(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!sample_valid);
  endtask

  function automatic int expected_sample();
    int s = 0;
    for (int v = 0; v < 3; v++) begin
      int a = (m_wave[v] << 5) | ((m_acc[v] >> 15) & 31);
      s += (nib_of(a) * m_vol[v]) >> 4;
    end
    return s << 2;
  endfunction

  task automatic next_sample(input string req);
    int c;
    wait_valid(c);
    for (int v = 0; v < 3; v++) m_acc[v] = (m_acc[v] + m_freq[v]) & 32'hFFFFF;
    chk(req, int'(sample), expected_sample());
  endtask

  task automatic t_reset;
    chk("R1 sample", int'(sample), 0);
    chk("R1 valid", int'(sample_valid), 0);
    chk("R1 pwm", int'(pwm), 0);
    next_sample("R1 first sample with cleared registers");
  endtask

  task automatic t_single_voice;
    set_voice(0, 32'h08000, 15, 3);
    for (int i = 0; i < 4; i++) next_sample("R2 single voice");
  endtask

  task automatic t_three_voices;
    set_voice(1, 32'h12345, 9, 7);
    set_voice(2, 32'h0ABCD, 4, 12);
    for (int i = 0; i < 5; i++) next_sample("R5 three-voice mix");
  endtask

  task automatic t_nibble;
    set_voice(0, 32'h1F000, 15, 9);
    for (int i = 0; i < 3; i++) next_sample("R3 upper nibble ignored");
  endtask

  task automatic t_volume;
    bus_wr(16'h5043, 0);
    bus_wr(16'h504B, 1);
    for (int i = 0; i < 3; i++) next_sample("R4 volume scaling and mute");
    bus_wr(16'h5043, 12);
    next_sample("R4 volume restored");
  endtask

  task automatic t_ignored;
    bus_wr(16'h5058, 8'hFF);
    bus_wr(16'h505B, 8'h0F);
    bus_wr(16'h5045, 8'hAA);
    bus_wr(16'h5046, 8'h55);
    bus_wr(16'h5047, 8'h33);
    bus_wr(16'h5060, 8'h77);
    bus_wr(16'h503F, 8'h12);
    bus_wr(16'h4040, 8'hEE);
    bus_wr(16'h5140, 8'hEE);
    for (int i = 0; i < 3; i++) next_sample("R7 out-of-map writes ignored");
  endtask

  task automatic t_wrap;
    bus_wr(16'h5050, 8'hFF);
    bus_wr(16'h5051, 8'hFF);
    bus_wr(16'h5052, 8'hFF);  // only low nibble kept
    bus_wr(16'h5053, 15);
    for (int i = 0; i < 4; i++) next_sample("R10 accumulator wrap");
  endtask

  task automatic t_period;
    int c;
    wait_valid(c);
    for (int v = 0; v < 3; v++) m_acc[v] = (m_acc[v] + m_freq[v]) & 32'hFFFFF;
    wait_valid(c);
    for (int v = 0; v < 3; v++) m_acc[v] = (m_acc[v] + m_freq[v]) & 32'hFFFFF;
    chk("R6 sample period", c, TICK_DIV);
    chk("R6 sample after period", int'(sample), expected_sample());
  endtask

  task automatic t_pwm;
    for (int i = 0; i < 3; i++) begin
      int ones = 0;
      next_sample("R8 sample before duty");
      repeat (300) @(negedge clk);
      for (int k = 0; k < 256; k++) begin
        if (pwm) ones++;
        @(negedge clk);
      end
      chk("R8 R9 pwm duty", ones, int'(sample));
    end
  endtask

  initial begin
    for (int v = 0; v < 3; v++) begin
      m_freq[v] = 0; m_vol[v] = 0; m_wave[v] = 0; m_acc[v] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_voice();
    t_three_voices();
    t_nibble();
    t_volume();
    t_ignored();
    t_wrap();
    t_period();
    t_pwm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule